// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an asynchronous static RAM of 32768 bytes (15 address lines, 8 data lines). The host places one read or one write on a valid/ready port. The controller turns each request into the active-low select, write-strobe and output-enable sequence that the memory expects. Read data returns on a one-cycle valid strobe.

Every phase length is a whole number of clock cycles. Each is derived at elaboration from the clock period and the memory's nanosecond minimums: read cycle, address access, write cycle, write pulse, data setup, and write-strobe-to-output-off. The memory data bus is split into an output value, an output enable and an input value. The surrounding pad logic combines them into the bidirectional pins.

Between requests the select line stays high, so the memory sits in its low-power standby state. A parameter picks one of two write styles. The default keeps output enable high through the whole write. The alternative keeps output enable low and stretches the write strobe so that the memory's drivers have turned off before data setup is counted.

Top module: `sram_ctl`

## Requirements
- R1: During reset and while idle, select, write strobe and output enable are all high, the data bus output enable is low, and `req_ready` and `rsp_valid` are low.
- R2: A read holds select and output enable low and the write strobe high for exactly max(ceil(tAA/Tclk), ceil(tRC/Tclk)) cycles.
- R3: Read data is sampled on the clock edge that ends ceil(tAA/Tclk) cycles of read-mode drive. `rsp_valid` is high for one cycle after that edge, with the sampled byte on `rsp_rdata`.
- R4: A read is acknowledged by a one-cycle `req_ready` in the cycle after the last read-mode cycle, so no read completes before the read cycle time.
- R5: A write first spends one cycle with select low and the write strobe high (address setup). The strobe then goes low. With `OE_LOW_WRITE`=0, output enable stays high for the whole write.
- R6: With `OE_LOW_WRITE`=0, the write strobe stays low for exactly ceil(max(tWP, tDW)/Tclk) cycles.
- R7: With `OE_LOW_WRITE`=1, output enable is low during the write and the strobe stays low for exactly ceil(max(tWP, tDW, tWHZ+tDW)/Tclk) cycles.
- R8: The controller drives the data bus only while select and the write strobe are both low. It never drives while the memory is in read mode.
- R9: The address bus stays constant for as long as select is low.
- R10: `req_ready` is a single-cycle pulse, during which select is already high. A request still valid in that cycle is not accepted again, so at least one standby cycle separates accesses.
- R11: A write is acknowledged in the cycle after select rises. Select stays low for max(ceil(tWC/Tclk), 1 + pulse cycles) cycles.
- R12: A read returns the byte most recently written to the same address. The strobed data equals `req_wdata` held over the whole pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held with its fields until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | One-cycle acknowledge at the end of the access |
| rsp_valid | output | 1 | One-cycle strobe marking read data |
| rsp_rdata | output | 8 | Read data |
| sram_cs_n | output | 1 | Memory select, active low |
| sram_we_n | output | 1 | Memory write strobe, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_addr | output | 15 | Memory address |
| sram_dq_out | output | 8 | Value to drive onto the data pins |
| sram_dq_oe | output | 1 | Drive enable for the data pins |
| sram_dq_in | input | 8 | Value read from the data pins |

## Verification
The embedded properties watch every cycle for the following:
- data bus drive only inside the write strobe, and no overlap with memory read mode;
- an address frozen under a low select;
- the strobe width at each rising edge of the strobe;
- output enable during writes matching the selected mode;
- single-cycle acknowledge and response pulses, with select already high at acknowledge.

The bench scenarios cover what those properties cannot show. A behavioural memory model returns a corrupted byte until enough full cycles of access time have elapsed. This exposes sampling that happens too early. Write-then-read data integrity, the exact acknowledge latencies, and both write styles are measured against cycle counts that the bench derives itself from the nanosecond figures.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WR_SU,
    ST_WR_PW,
    ST_WR_REC
  } st_e;

  // Round a nanosecond minimum up to whole clock cycles, never below one.
  function automatic int ns2cyc(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Strobe width: pulse minimum and data setup; with output enable low the
  // memory's driver turn-off time is added ahead of data setup.
  function automatic int strobe_cyc(input int t_wp, input int t_dw, input int t_whz,
                                    input int clk_ns, input int oe_low);
    int need;
    need = imax(t_wp, t_dw);
    if (oe_low != 0) need = imax(need, t_whz + t_dw);
    return ns2cyc(need, clk_ns);
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] count
);
  // Cycles spent in the current phase; saturates instead of wrapping.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               count <= '0;
    else if (restart)         count <= '0;
    else if (count != '1)     count <= count + 1'b1;
  end
endmodule

// File: rtl/sram_ctl_dq.sv
module sram_ctl_dq #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_wr,
  input  logic          drive_next,
  input  logic [DW-1:0] wdata,
  input  logic          capture,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_out <= '0;
      dq_oe  <= 1'b0;
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      dq_oe  <= drive_next;
      rvalid <= capture;
      if (load_wr) dq_out <= wdata;
      if (capture) rdata  <= dq_in;
    end
  end

  // R8: bus released in the cycle after the write phase ends
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_next) |=> !dq_oe);
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int AW           = 15,
  parameter int DW           = 8,
  parameter int CLK_NS       = 10,
  parameter int T_RC_NS      = 15,
  parameter int T_AA_NS      = 15,
  parameter int T_WC_NS      = 15,
  parameter int T_WP_NS      = 10,
  parameter int T_DW_NS      = 7,
  parameter int T_WHZ_NS     = 7,
  parameter int OE_LOW_WRITE = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          sram_cs_n,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  output logic [AW-1:0] sram_addr,
  output logic [DW-1:0] sram_dq_out,
  output logic          sram_dq_oe,
  input  logic [DW-1:0] sram_dq_in
);
  localparam int AA_CYC  = ns2cyc(T_AA_NS, CLK_NS);
  localparam int RC_CYC  = ns2cyc(T_RC_NS, CLK_NS);
  localparam int WC_CYC  = ns2cyc(T_WC_NS, CLK_NS);
  localparam int WP_CYC  = strobe_cyc(T_WP_NS, T_DW_NS, T_WHZ_NS, CLK_NS, OE_LOW_WRITE);
  localparam int RD_CYC  = imax(AA_CYC, RC_CYC);
  localparam int WR_CYC  = imax(WC_CYC, 1 + WP_CYC);
  localparam int REC_CYC = WR_CYC - 1 - WP_CYC;
  localparam int CNT_W   = $clog2(imax(RD_CYC, WR_CYC) + 1);

  st_e              st_q, st_d;
  logic [CNT_W-1:0] ph_cnt;

  // Named internal events
  logic accept, rd_cap_ev, rd_end_ev, pw_end_ev, rec_end_ev, wr_end_ev;
  assign accept     = (st_q == ST_IDLE) && req_valid && !req_ready;
  assign rd_cap_ev  = (st_q == ST_RD) && (ph_cnt == CNT_W'(AA_CYC - 1));
  assign rd_end_ev  = (st_q == ST_RD) && (ph_cnt == CNT_W'(RD_CYC - 1));
  assign pw_end_ev  = (st_q == ST_WR_PW) && (ph_cnt == CNT_W'(WP_CYC - 1));
  assign rec_end_ev = (st_q == ST_WR_REC) && (REC_CYC > 0) &&
                      (ph_cnt == CNT_W'(REC_CYC - 1));
  assign wr_end_ev  = (pw_end_ev && (REC_CYC == 0)) || rec_end_ev;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (accept) st_d = req_write ? ST_WR_SU : ST_RD;
      ST_RD:     if (rd_end_ev) st_d = ST_IDLE;
      ST_WR_SU:  st_d = ST_WR_PW;
      ST_WR_PW:  if (pw_end_ev) st_d = (REC_CYC > 0) ? ST_WR_REC : ST_IDLE;
      ST_WR_REC: if (rec_end_ev) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  logic oe_next;
  assign oe_next = (st_d == ST_RD) ||
                   ((OE_LOW_WRITE != 0) &&
                    (st_d == ST_WR_SU || st_d == ST_WR_PW || st_d == ST_WR_REC));

  // Memory strobes are registered decodes of the next state: no glitches.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      sram_cs_n <= 1'b1;
      sram_we_n <= 1'b1;
      sram_oe_n <= 1'b1;
      sram_addr <= '0;
      req_ready <= 1'b0;
    end else begin
      st_q      <= st_d;
      sram_cs_n <= (st_d == ST_IDLE);
      sram_we_n <= (st_d != ST_WR_PW);
      sram_oe_n <= !oe_next;
      if (accept) sram_addr <= req_addr;
      req_ready <= rd_end_ev || wr_end_ev;
    end
  end

  sram_ctl_timer #(.W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (st_d != st_q),
    .count   (ph_cnt)
  );

  sram_ctl_dq #(.DW(DW)) u_dq (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_wr    (accept),
    .drive_next (st_d == ST_WR_PW),
    .wdata      (req_wdata),
    .capture    (rd_cap_ev),
    .dq_in      (sram_dq_in),
    .dq_out     (sram_dq_out),
    .dq_oe      (sram_dq_oe),
    .rdata      (rsp_rdata),
    .rvalid     (rsp_valid)
  );

  // Checker-side run length of the write strobe
  logic [CNT_W-1:0] we_lo_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         we_lo_run <= '0;
    else if (sram_we_n) we_lo_run <= '0;
    else                we_lo_run <= we_lo_run + 1'b1;
  end

  a_r1_idle_standby: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> (sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe));
  a_r8_drive_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> (!sram_we_n && !sram_cs_n));
  a_r8_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_cs_n && !sram_oe_n && sram_we_n) |-> !sram_dq_oe);
  a_r9_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr));
  a_r6_r7_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (we_lo_run == CNT_W'(WP_CYC)));
  a_r5_r7_oe_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (sram_oe_n == (OE_LOW_WRITE == 0)));
  a_r10_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);
  a_r10_ack_in_standby: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> sram_cs_n);
  a_r3_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: tb/sram_ctl_test.sv
`timescale 1ns/1ps

module sram_ctl_model #(
  parameter int AW = 15,
  parameter int DW = 8,
  parameter int AA_CYC = 2,
  parameter int WP_MIN = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq_out,
  input  logic          dq_oe,
  output logic [DW-1:0] dq_in,
  output int            faults
);
  logic [DW-1:0] mem [logic [AW-1:0]];
  int            rd_run, wp_run;
  logic          rd_prev, wr_prev;
  logic [AW-1:0] a_prev;
  logic [DW-1:0] d_prev;
  logic          rd_mode, wr_mode;
  assign rd_mode = !cs_n && we_n && !oe_n;
  assign wr_mode = !cs_n && !we_n;

  function automatic logic [DW-1:0] peek(input logic [AW-1:0] ad);
    return mem.exists(ad) ? mem[ad] : '0;
  endfunction

  // Byte is correct only once enough whole cycles of access have elapsed.
  always @(negedge clk)
    dq_in <= (rd_mode && rd_run >= AA_CYC - 1) ? peek(addr) : ~peek(addr);

  always @(posedge clk) begin
    if (!rst_n) begin
      faults = 0; rd_run = 0; wp_run = 0;
      rd_prev = 1'b0; wr_prev = 1'b0; a_prev = '0; d_prev = '0;
    end else begin
      if (dq_oe && (we_n || cs_n)) faults++;
      if (rd_mode) rd_run = (rd_prev && addr == a_prev) ? rd_run + 1 : 1;
      else rd_run = 0;
      if (wr_mode) begin
        if (wr_prev && (addr != a_prev || dq_out != d_prev)) faults++;
        if (!dq_oe) faults++;
        wp_run = wr_prev ? wp_run + 1 : 1;
      end else if (wr_prev) begin
        if (wp_run < WP_MIN) faults++;
        mem[a_prev] = d_prev;
        wp_run = 0;
      end
      rd_prev = rd_mode; wr_prev = wr_mode; a_prev = addr; d_prev = dq_out;
    end
  end
endmodule

module sram_ctl_test;
  localparam int CLK_NS = 10;
  localparam int T_RC = 15, T_AA = 15, T_WC = 15, T_WP = 10, T_DW = 7, T_WHZ = 7;

  function automatic int tb_cyc(input int ns);
    int n = 1;
    while (n * CLK_NS < ns) n++;
    return n;
  endfunction
  function automatic int tb_max(input int x, input int y);
    return (x > y) ? x : y;
  endfunction
  function automatic int exp_pulse(input int oe_low);
    int need = tb_max(T_WP, T_DW);
    if (oe_low != 0) need = tb_max(need, T_WHZ + T_DW);
    return tb_cyc(need);
  endfunction
  function automatic int exp_rd_drive();
    return tb_max(tb_cyc(T_AA), tb_cyc(T_RC));
  endfunction
  function automatic int exp_wr_sel(input int oe_low);
    return tb_max(tb_cyc(T_WC), 1 + exp_pulse(oe_low));
  endfunction

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_NS / 2) clk = ~clk;

  logic        v [2], w [2];
  logic [14:0] a [2];
  logic [7:0]  d [2];
  logic        rdy [2], rv [2], cs [2], we [2], oe [2], moe [2];
  logic [7:0]  rd [2], mo [2], mi [2];
  logic [14:0] ma [2];
  int          flt [2];

  sram_ctl #(.OE_LOW_WRITE(0)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(v[0]), .req_write(w[0]), .req_addr(a[0]),
    .req_wdata(d[0]), .req_ready(rdy[0]), .rsp_valid(rv[0]), .rsp_rdata(rd[0]),
    .sram_cs_n(cs[0]), .sram_we_n(we[0]), .sram_oe_n(oe[0]), .sram_addr(ma[0]),
    .sram_dq_out(mo[0]), .sram_dq_oe(moe[0]), .sram_dq_in(mi[0]));
  sram_ctl #(.OE_LOW_WRITE(1)) uut_oe (
    .clk(clk), .rst_n(rst_n), .req_valid(v[1]), .req_write(w[1]), .req_addr(a[1]),
    .req_wdata(d[1]), .req_ready(rdy[1]), .rsp_valid(rv[1]), .rsp_rdata(rd[1]),
    .sram_cs_n(cs[1]), .sram_we_n(we[1]), .sram_oe_n(oe[1]), .sram_addr(ma[1]),
    .sram_dq_out(mo[1]), .sram_dq_oe(moe[1]), .sram_dq_in(mi[1]));

  sram_ctl_model #(.AA_CYC(tb_cyc(T_AA)), .WP_MIN(exp_pulse(0))) mdl0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs[0]), .we_n(we[0]), .oe_n(oe[0]), .addr(ma[0]),
    .dq_out(mo[0]), .dq_oe(moe[0]), .dq_in(mi[0]), .faults(flt[0]));
  sram_ctl_model #(.AA_CYC(tb_cyc(T_AA)), .WP_MIN(exp_pulse(1))) mdl1 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs[1]), .we_n(we[1]), .oe_n(oe[1]), .addr(ma[1]),
    .dq_out(mo[1]), .dq_oe(moe[1]), .dq_in(mi[1]), .faults(flt[1]));

  logic [7:0] sh0 [logic [14:0]];
  logic [7:0] sh1 [logic [14:0]];
  function automatic logic [7:0] shadow(input int u, input logic [14:0] ad);
    if (u == 0) return sh0.exists(ad) ? sh0[ad] : 8'h00;
    return sh1.exists(ad) ? sh1[ad] : 8'h00;
  endfunction

  int n_cmp = 0, n_bad = 0;
  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle_check(input int u);
    check("R1", "cs_n idle", int'(cs[u]), 1);
    check("R1", "we_n idle", int'(we[u]), 1);
    check("R1", "oe_n idle", int'(oe[u]), 1);
    check("R1", "dq_oe idle", int'(moe[u]), 0);
    check("R1", "ready/rsp idle", int'(rdy[u]) + int'(rv[u]), 0);
  endtask

  task automatic do_op(input int u, input bit wr, input logic [14:0] ad, input logic [7:0] dt);
    int n = 0, we_lo = 0, oe_in_we = 0, rd_mode = 0, rsp_at = 0, addr_bad = 0, drv_bad = 0;
    int data_bad = 0;
    logic [7:0] got = '0;
    bit done = 0;
    @(negedge clk);
    v[u] = 1'b1; w[u] = wr; a[u] = ad; d[u] = dt;
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
      if (!we[u]) begin
        we_lo++;
        if (!oe[u]) oe_in_we++;
        if (mo[u] != dt || !moe[u]) data_bad++;
      end
      if (!cs[u] && we[u] && !oe[u]) rd_mode++;
      if (!cs[u] && ma[u] != ad) addr_bad++;
      if (moe[u] && (we[u] || cs[u])) drv_bad++;
      if (rv[u]) begin rsp_at = n; got = rd[u]; end
      if (rdy[u]) begin
        done = 1;
        check("R10", "select high at ack", int'(cs[u]), 1);
        v[u] = 1'b0;
      end
    end
    check("R10", "ack seen", int'(done), 1);
    check("R9", "address under select", addr_bad, 0);
    check("R8", "drive outside strobe", drv_bad, 0);
    if (wr) begin
      check("R11", "write ack latency", n, exp_wr_sel(u) + 1);
      if (u == 0) begin
        check("R6", "strobe cycles", we_lo, exp_pulse(0));
        check("R5", "oe low during strobe", oe_in_we, 0);
        sh0[ad] = dt;
      end else begin
        check("R7", "stretched strobe cycles", we_lo, exp_pulse(1));
        check("R7", "oe low during strobe", oe_in_we, exp_pulse(1));
        sh1[ad] = dt;
      end
      check("R12", "strobed data", data_bad, 0);
      check("R5", "setup: no read drive before strobe", (u == 0) ? rd_mode : 0, 0);
    end else begin
      check("R2", "read-mode cycles", rd_mode, exp_rd_drive());
      check("R4", "read ack latency", n, exp_rd_drive() + 1);
      check("R3", "rsp_valid cycle", rsp_at, tb_cyc(T_AA) + 1);
      check("R12", "read data", int'(got), int'(shadow(u, ad)));
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int u = 0; u < 2; u++) begin v[u] = 0; w[u] = 0; a[u] = '0; d[u] = '0; end
    repeat (3) @(negedge clk);
    idle_check(0); idle_check(1);                      // R1 during reset
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle_check(0); idle_check(1);                      // R1 idle after reset
    for (int u = 0; u < 2; u++) begin
      do_op(u, 0, 15'h0000, 8'h00);                    // unwritten location
      do_op(u, 1, 15'h0000, 8'hFF);
      do_op(u, 1, 15'h7FFF, 8'h00);
      do_op(u, 0, 15'h0000, 8'h00);
      do_op(u, 0, 15'h7FFF, 8'h00);
      do_op(u, 1, 15'h2AAA, 8'h5A);
      do_op(u, 1, 15'h2AAA, 8'hA5);                    // overwrite
      do_op(u, 0, 15'h2AAA, 8'h00);
    end
    for (int i = 0; i < 300; i++) begin
      int u = int'($urandom % 2);
      bit wr = 1'($urandom % 2);
      logic [14:0] ad = ($urandom % 4 == 0) ? 15'($urandom) : 15'(($urandom % 24) * 1021);
      do_op(u, wr, ad, 8'($urandom));
    end
    repeat (3) @(negedge clk);
    idle_check(0); idle_check(1);
    check("R8", "model faults, oe-high writes", flt[0], 0);
    check("R7", "model faults, oe-low writes", flt[1], 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule